// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one burst request into the sequence of column addresses a synchronous DRAM page access walks through. A one-cycle start pulse captures a start column, a burst-length code and an order bit. From the next cycle on, the block presents one column per clock, with a valid strobe, until the burst runs out, a stop request arrives, or a new start replaces it.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the naturally aligned block of that size that holds the start column. Within that block they either count upward and wrap, or visit columns in XOR (interleaved) order. Full-page bursts count through the whole 256-column page, wrapping from the top back to zero. They have no natural end, so a stop request must close them. Bank and row selection, data movement and command encoding are handled elsewhere.

Top module: `sdram_burst_col_gen`

## Requirements
- R1: While rst_ni is low and after reset, valid_o and last_o are 0 and col_o is 0.
- R2: A start_i sampled high at a clock edge makes valid_o high with col_o equal to the captured start column in the following cycle. Each later cycle of the burst presents the next beat.
- R3: With order bit interleave_i = 0 and length L of 2, 4 or 8 (codes 3'b001, 3'b010, 3'b011), beat i shows the start column with its low log2(L) bits replaced by (low bits + i) mod L. The upper bits are unchanged.
- R4: With interleave_i = 1 and length L of 2, 4 or 8, beat i shows the start column XOR i.
- R5: Code 3'b000 gives a single beat. Codes 3'b100, 3'b101 and 3'b110 also give a single beat.
- R6: Code 3'b111 selects full page. Beat i is (start + i) mod 256 whatever the order bit, and the burst continues with no end of its own.
- R7: last_o is high exactly on the final beat of a fixed-length burst. A burst ends after that beat. last_o is never high in a full-page burst.
- R8: stop_i sampled high during a beat with start_i low makes that beat the last one, and valid_o is low on the next cycle. stop_i has no effect while idle.
- R9: start_i during a burst discards the old burst. The next cycle shows beat 0 of the new one, and start_i takes priority over stop_i.
- R10: col_o is 0 whenever valid_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new burst with the inputs below |
| start_col_i | input | 8 | First column of the burst |
| blen_i | input | 3 | Burst-length code |
| interleave_i | input | 1 | 1 = interleaved order, 0 = sequential |
| stop_i | input | 1 | End the running burst after the current beat |
| col_o | output | 8 | Current column |
| valid_o | output | 1 | col_o carries a beat |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
A corrupted beat counter, base or mask register shows on col_o in the very next beat. The bench compares every cycle, so a single wrong column within a wrap or XOR pattern is caught at once. A wrong length or a lost termination shows as valid_o staying high one cycle too long, or dropping too early. last_o is checked on the same cycle. Full-page runs longer than 256 beats expose a counter that saturates or fails to wrap.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;
  typedef enum logic [2:0] {
    BL_1    = 3'b000,
    BL_2    = 3'b001,
    BL_4    = 3'b010,
    BL_8    = 3'b011,
    BL_PAGE = 3'b111
  } blen_code_e;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [2:0]       blen_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  always_comb begin
    full_o = (blen_i == BL_PAGE);
    if (full_o)         mask_o = '1;
    else if (blen_i[2]) mask_o = '0;  // reserved codes: single beat
    else                mask_o = (ONE << blen_i[1:0]) - ONE;
  end
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             il_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum_w;
  assign sum_w = base_i + beat_i;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    always_comb begin
      if (!mask_i[b])  col_o[b] = base_i[b];
      else if (il_i)   col_o[b] = base_i[b] ^ beat_i[b];
      else             col_o[b] = sum_w[b];
    end
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             il_i,
  input  logic             stop_i,
  output logic             active_o,
  output logic             last_o,
  output logic             full_o,
  output logic             il_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] mask_o
);
  logic             active_q, full_q, il_q;
  logic [COL_W-1:0] base_q, beat_q, mask_q;
  logic             last_w;

  assign last_w = active_q & ~full_q & (beat_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      il_q     <= 1'b0;
      base_q   <= '0;
      beat_q   <= '0;
      mask_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      full_q   <= full_i;
      il_q     <= il_i & ~full_i;  // full page is always sequential
      base_q   <= start_col_i;
      beat_q   <= '0;
      mask_q   <= mask_i;
    end else if (active_q) begin
      if (stop_i || last_w) active_q <= 1'b0;
      else                  beat_q   <= beat_q + COL_W'(1);
    end
  end

  assign active_o = active_q;
  assign last_o   = last_w;
  assign full_o   = full_q;
  assign il_o     = il_q;
  assign base_o   = base_q;
  assign beat_o   = beat_q;
  assign mask_o   = mask_q;
endmodule

// File: rtl/sdram_burst_col_gen.sv
module sdram_burst_col_gen #(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       blen_i,
  input  logic             interleave_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [COL_W-1:0] dec_mask, base_w, beat_w, mask_w, col_w;
  logic             dec_full, active_w, last_w, full_w, il_w;

  burst_len_decode #(.COL_W(COL_W)) u_dec (
    .blen_i (blen_i),
    .mask_o (dec_mask),
    .full_o (dec_full)
  );

  burst_seq #(.COL_W(COL_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .mask_i      (dec_mask),
    .full_i      (dec_full),
    .il_i        (interleave_i),
    .stop_i      (stop_i),
    .active_o    (active_w),
    .last_o      (last_w),
    .full_o      (full_w),
    .il_o        (il_w),
    .base_o      (base_w),
    .beat_o      (beat_w),
    .mask_o      (mask_w)
  );

  burst_col_map #(.COL_W(COL_W)) u_map (
    .base_i (base_w),
    .beat_i (beat_w),
    .mask_i (mask_w),
    .il_i   (il_w),
    .col_o  (col_w)
  );

  assign valid_o = active_w;
  assign last_o  = last_w;
  assign col_o   = active_w ? col_w : '0;

  assert_start_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  assert_page_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && full_w && !start_i && !stop_i) |=>
      (valid_o && !last_o && col_o == COL_W'($past(col_o) + COL_W'(1))));

  assert_last_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  assert_last_ends_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !valid_o);

  assert_stop_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && stop_i && !start_i) |=> !valid_o);

  assert_idle_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (col_o == '0 && !last_o));
endmodule

// File: tb/sdram_burst_col_gen_tb.sv
module sdram_burst_col_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] scol = '0;
  logic [2:0] blen = '0;
  logic       il = 1'b0;
  logic       stop = 1'b0;
  logic [7:0] col;
  logic       valid, last;

  int    n_run = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";
  int    q[$];
  bit    m_full = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sdram_burst_col_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_col_i(scol),
    .blen_i(blen), .interleave_i(il), .stop_i(stop),
    .col_o(col), .valid_o(valid), .last_o(last)
  );

  function automatic void build(int s, int code, bit ilv);
    int len;
    q.delete();
    m_full = (code == 7);
    case (code)
      1: len = 2;
      2: len = 4;
      3: len = 8;
      default: len = 1;
    endcase
    if (m_full) begin
      for (int i = 0; i < 1024; i++) q.push_back((s + i) % 256);
    end else begin
      for (int i = 0; i < len; i++) begin
        if (ilv) q.push_back(s ^ i);
        else     q.push_back((s - s % len) + (s % len + i) % len);
      end
    end
  endfunction

  // reference model: front of queue is the beat on the ports
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) q.delete();
    else if (start) build(int'(scol), int'(blen), il);
    else if (q.size() > 0) begin
      if (stop) q.delete();
      else void'(q.pop_front());
    end
  end

  always @(negedge clk) begin
    bit  ev, el;
    int  ec;
    ev = q.size() > 0;
    ec = ev ? q[0] : 0;
    el = (q.size() == 1) && !m_full;
    n_run++;
    if (valid !== ev || last !== el || int'(col) !== ec) begin
      n_fail++;
      $display("FAIL %s cyc %0d: valid/last/col got %0b/%0b/%0h exp %0b/%0b/%0h",
               cur_req, cyc, valid, last, col, ev, el, ec);
    end
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: cycles got %0d exp <= 100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic go(input logic [7:0] c, input logic [2:0] b, input logic i);
    @(negedge clk);
    start = 1'b1; scol = c; blen = b; il = i; stop = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic stop_now;
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  initial begin
    cur_req = "R1";
    idle(3);
    rst_n = 1'b1;
    idle(2);
    cur_req = "R3"; go(8'h35, 3'b011, 1'b0); idle(9);
    go(8'hfe, 3'b010, 1'b0); idle(5);
    go(8'h81, 3'b001, 1'b0); idle(3);
    cur_req = "R4"; go(8'h35, 3'b011, 1'b1); idle(9);
    go(8'h6a, 3'b010, 1'b1); idle(5);
    go(8'h13, 3'b001, 1'b1); idle(3);
    cur_req = "R5"; go(8'h44, 3'b000, 1'b0); idle(2);
    go(8'h45, 3'b100, 1'b1); idle(2);
    go(8'h46, 3'b101, 1'b0); idle(2);
    go(8'h47, 3'b110, 1'b0); idle(2);
    cur_req = "R6"; go(8'hf0, 3'b111, 1'b1); idle(300);
    cur_req = "R8"; stop_now(); idle(3);
    stop_now(); idle(2);
    go(8'h20, 3'b011, 1'b0); idle(2); stop_now(); idle(4);
    go(8'h00, 3'b111, 1'b0); idle(5); stop_now(); idle(3);
    cur_req = "R9"; go(8'h10, 3'b011, 1'b0); idle(2);
    go(8'h57, 3'b010, 1'b1); idle(1);
    @(negedge clk);
    start = 1'b1; scol = 8'hc3; blen = 3'b111; il = 1'b0; stop = 1'b1;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    idle(4); stop_now(); idle(2);
    cur_req = "R7"; go(8'h09, 3'b001, 1'b0);
    go(8'h0a, 3'b001, 1'b1); idle(4);
    cur_req = "R1";
    @(negedge clk); rst_n = 1'b0;
    idle(3);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule